// File: doc/BRIEF.md
# Packed-Symbol Error Correction Applier

This block takes the corrections that a Reed-Solomon decoder has reported for one 512-byte data chunk and applies them to the chunk. The chunk sits in a byte-wide RAM. Each code symbol is 9 bits wide and is packed across byte boundaries, so one symbol usually spans two neighbouring bytes. Each correction arrives as a 9-bit symbol index and a 9-bit error mask. The block finds the byte pair that the symbol covers and reads both bytes. It XORs the mask in at the right bit offset and writes both bytes back. This fixed read, read, write, write sequence runs on a single-ported RAM that returns read data one cycle after the request.

A job starts with a one-cycle `start_i`. At that edge the block captures a count and a list of up to four index/mask pairs. The entries are applied in list order, and `done_o` pulses once the last entry has been handled. A job is dropped without touching the RAM in two cases: the count is outside the accepted range, or the decoder has flagged the chunk as uncorrectable. The uncorrectable flag is copied to `err_o`.

Top module: `rs_err_apply`

## Requirements
- R1: Data bit n of the buffer is bit (n mod 8) of byte (n div 8). A symbol index s in the range 1 to 456 covers bits 9(s-1) through 9(s-1)+8. Mask bit t flips bit 9(s-1)+t. Mask bits that land at or beyond bit 4096 are dropped.
- R2: Let b be the byte that holds the upper end of the symbol. Each applied entry takes four consecutive cycles: read b, read b-1, write b-1, write b. Each write goes to the address that was read in that same sequence.
- R3: When b equals 512 (symbol 456), only byte 511 is read and written. No other byte changes.
- R4: An entry with index 0 or an index above 456 is skipped. It causes no RAM access and takes one cycle.
- R5: A count of 0 or of 5 to 7 (`cnt_i` is 3 bits) causes no RAM access. `done_o` pulses in the cycle after the start edge.
- R6: When `uncor_i` is high at the start edge, no correction is applied and `done_o` pulses in the next cycle. `err_o` takes the value of `uncor_i` from that start edge and holds it until the next accepted start.
- R7: `done_o` is a one-cycle pulse. Its latency is counted in cycles from the start edge: it is 4·applied + skipped + 1. There is no RAM access outside a job.
- R8: A `start_i` that arrives while a job is running is ignored.
- R9: Entries are applied in list order and each one sees the result of the one before. Two entries that hit the same bits combine by XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a job when the block is idle |
| uncor_i | input | 1 | Uncorrectable flag from the decoder |
| cnt_i | input | 3 | Number of listed corrections |
| idx_list_i | input | 36 | Symbol indices; entry k is bits [9k+8:9k] |
| mask_list_i | input | 36 | Error masks; entry k is bits [9k+8:9k] |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write when set, read otherwise |
| mem_addr_o | output | 9 | RAM byte address |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, valid one cycle after a read |
| done_o | output | 1 | One-cycle pulse at job end |
| err_o | output | 1 | Uncorrectable flag of the last accepted job |

## Verification
The assertions assume that the RAM returns the addressed byte exactly one cycle after each read. They also assume that `start_i` is a single-cycle pulse, with the count and lists held stable from that edge on. The bench RAM model returns data with that latency. The bench driver raises start only at negative edges and holds the inputs for a full cycle. It pulses start during a running job only in the R8 check, and the checker treats that pulse as ignored.

// File: rtl/rs_apply_pkg.sv
package rs_apply_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_HI,
    ST_RD_LO,
    ST_WR_LO,
    ST_WR_HI,
    ST_FIN
  } ap_state_e;
endpackage

// File: rtl/rs_sym_locate.sv
// Maps a packed symbol index onto the byte pair it spans and aligns its mask.
module rs_sym_locate #(
  parameter int SYM_W  = 9,
  parameter int BYTES  = 512,
  parameter int ADDR_W = 9
) (
  input  logic [SYM_W-1:0]  idx_i,
  input  logic [SYM_W-1:0]  mask_i,
  output logic [ADDR_W-1:0] hi_addr_o,
  output logic [ADDR_W-1:0] lo_addr_o,
  output logic [7:0]        hi_flip_o,
  output logic [7:0]        lo_flip_o,
  output logic              valid_o,
  output logic              single_o
);
  localparam int POS_W = SYM_W + $clog2(SYM_W) + 1;
  localparam int BI_W  = POS_W - 3;

  logic [POS_W-1:0] pos;
  logic [BI_W-1:0]  bidx;
  logic [2:0]       sh;
  logic [15:0]      word;

  assign pos = POS_W'(idx_i) * POS_W'(SYM_W);

  always_comb begin
    if (pos[2:0] == 3'd0) begin
      bidx = pos[POS_W-1:3] - BI_W'(1);
      sh   = 3'd7;
    end else begin
      bidx = pos[POS_W-1:3];
      sh   = pos[2:0] - 3'd1;
    end
  end

  // index 0 would underflow to byte -1
  assign valid_o   = (idx_i != '0) && (bidx <= BI_W'(BYTES));
  assign single_o  = (bidx == BI_W'(BYTES));
  assign word      = 16'(mask_i) << sh;
  assign lo_flip_o = word[7:0];
  assign hi_flip_o = word[15:8];
  assign hi_addr_o = ADDR_W'(bidx);
  assign lo_addr_o = ADDR_W'(bidx - BI_W'(1));
endmodule

// File: rtl/rs_corr_list.sv
// Holds the correction list captured at job start; presents one entry.
module rs_corr_list #(
  parameter int SYM_W    = 9,
  parameter int MAX_CORR = 4,
  parameter int SEL_W    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [MAX_CORR*SYM_W-1:0] idx_list_i,
  input  logic [MAX_CORR*SYM_W-1:0] mask_list_i,
  input  logic [SEL_W-1:0]          sel_i,
  output logic [SYM_W-1:0]          idx_o,
  output logic [SYM_W-1:0]          mask_o
);
  logic [SYM_W-1:0] idx_q  [MAX_CORR];
  logic [SYM_W-1:0] mask_q [MAX_CORR];

  for (genvar k = 0; k < MAX_CORR; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_q[k]  <= '0;
        mask_q[k] <= '0;
      end else if (load_i) begin
        idx_q[k]  <= idx_list_i[k*SYM_W +: SYM_W];
        mask_q[k] <= mask_list_i[k*SYM_W +: SYM_W];
      end
    end
  end

  assign idx_o  = idx_q[sel_i];
  assign mask_o = mask_q[sel_i];
endmodule

// File: rtl/rs_apply_fsm.sv
// Sequencer: read hi, read lo, write lo, write hi per entry.
module rs_apply_fsm
  import rs_apply_pkg::*;
#(
  parameter int MAX_CORR = 4,
  parameter int ADDR_W   = 9,
  parameter int CNT_W    = 3,
  parameter int SEL_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              uncor_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ent_valid_i,
  input  logic              ent_single_i,
  input  logic [ADDR_W-1:0] hi_addr_i,
  input  logic [ADDR_W-1:0] lo_addr_i,
  input  logic [7:0]        hi_flip_i,
  input  logic [7:0]        lo_flip_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              load_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              done_o,
  output logic              err_o
);
  ap_state_e        state_q;
  logic [SEL_W-1:0] sel_q, last_q;
  logic [7:0]       hi_q;
  logic             err_q;
  logic             cnt_ok, is_last;

  assign cnt_ok  = (cnt_i != '0) && (cnt_i <= CNT_W'(MAX_CORR));
  assign is_last = (sel_q == last_q);
  assign load_o  = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      last_q  <= '0;
      hi_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          err_q   <= uncor_i;
          sel_q   <= '0;
          last_q  <= SEL_W'(cnt_i - CNT_W'(1));
          state_q <= (uncor_i || !cnt_ok) ? ST_FIN : ST_RD_HI;
        end
        ST_RD_HI: begin
          if (ent_valid_i) state_q <= ST_RD_LO;
          else if (is_last) state_q <= ST_FIN;
          else sel_q <= sel_q + SEL_W'(1);
        end
        ST_RD_LO: begin
          hi_q    <= mem_rdata_i;
          state_q <= ST_WR_LO;
        end
        ST_WR_LO: state_q <= ST_WR_HI;
        ST_WR_HI: begin
          if (is_last) state_q <= ST_FIN;
          else begin
            sel_q   <= sel_q + SEL_W'(1);
            state_q <= ST_RD_HI;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      ST_RD_HI: begin
        mem_en_o   = ent_valid_i && !ent_single_i;
        mem_addr_o = hi_addr_i;
      end
      ST_RD_LO: begin
        mem_en_o   = 1'b1;
        mem_addr_o = lo_addr_i;
      end
      ST_WR_LO: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = lo_addr_i;
        mem_wdata_o = mem_rdata_i ^ lo_flip_i;
      end
      ST_WR_HI: begin
        mem_en_o    = !ent_single_i;
        mem_we_o    = 1'b1;
        mem_addr_o  = hi_addr_i;
        mem_wdata_o = hi_q ^ hi_flip_i;
      end
      default: ;
    endcase
  end

  assign sel_o  = sel_q;
  assign done_o = (state_q == ST_FIN);
  assign err_o  = err_q;
endmodule

// File: rtl/rs_err_apply.sv
module rs_err_apply #(
  parameter int SYM_W    = 9,
  parameter int BYTES    = 512,
  parameter int MAX_CORR = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        uncor_i,
  input  logic [$clog2(MAX_CORR):0]   cnt_i,
  input  logic [MAX_CORR*SYM_W-1:0]   idx_list_i,
  input  logic [MAX_CORR*SYM_W-1:0]   mask_list_i,
  output logic                        mem_en_o,
  output logic                        mem_we_o,
  output logic [$clog2(BYTES)-1:0]    mem_addr_o,
  output logic [7:0]                  mem_wdata_o,
  input  logic [7:0]                  mem_rdata_i,
  output logic                        done_o,
  output logic                        err_o
);
  localparam int ADDR_W = $clog2(BYTES);
  localparam int CNT_W  = $clog2(MAX_CORR) + 1;
  localparam int SEL_W  = $clog2(MAX_CORR);

  logic              load;
  logic [SEL_W-1:0]  sel;
  logic [SYM_W-1:0]  ent_idx, ent_mask;
  logic [ADDR_W-1:0] hi_addr, lo_addr;
  logic [7:0]        hi_flip, lo_flip;
  logic              ent_valid, ent_single;

  rs_corr_list #(.SYM_W(SYM_W), .MAX_CORR(MAX_CORR), .SEL_W(SEL_W)) i_list (
    .clk_i, .rst_ni, .load_i(load), .idx_list_i, .mask_list_i,
    .sel_i(sel), .idx_o(ent_idx), .mask_o(ent_mask)
  );

  rs_sym_locate #(.SYM_W(SYM_W), .BYTES(BYTES), .ADDR_W(ADDR_W)) i_loc (
    .idx_i(ent_idx), .mask_i(ent_mask), .hi_addr_o(hi_addr), .lo_addr_o(lo_addr),
    .hi_flip_o(hi_flip), .lo_flip_o(lo_flip), .valid_o(ent_valid), .single_o(ent_single)
  );

  rs_apply_fsm #(.MAX_CORR(MAX_CORR), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) i_fsm (
    .clk_i, .rst_ni, .start_i, .uncor_i, .cnt_i,
    .ent_valid_i(ent_valid), .ent_single_i(ent_single),
    .hi_addr_i(hi_addr), .lo_addr_i(lo_addr), .hi_flip_i(hi_flip), .lo_flip_i(lo_flip),
    .mem_rdata_i, .load_o(load), .sel_o(sel),
    .mem_en_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .done_o, .err_o
  );
endmodule

// File: rtl/rs_err_apply_chk.sv
module rs_err_apply_chk #(
  parameter int BYTES    = 512,
  parameter int MAX_CORR = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      start_i,
  input logic                      uncor_i,
  input logic [$clog2(MAX_CORR):0] cnt_i,
  input logic                      mem_en_o,
  input logic                      mem_we_o,
  input logic [$clog2(BYTES)-1:0]  mem_addr_o,
  input logic                      done_o,
  input logic                      err_o
);
  localparam int ADDR_W = $clog2(BYTES);
  localparam int CNT_W  = $clog2(MAX_CORR) + 1;

  logic busy_q, accept, bad_cnt;
  assign accept  = start_i && !busy_q;
  assign bad_cnt = (cnt_i == '0) || (cnt_i > CNT_W'(MAX_CORR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (accept) busy_q <= 1'b1;
    else if (done_o) busy_q <= 1'b0;
  end

  p_rmw_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && mem_we_o) |->
      (($past(mem_en_o && !mem_we_o) && mem_addr_o == $past(mem_addr_o)) ||
       ($past(mem_en_o && mem_we_o) && $past(mem_en_o && !mem_we_o, 2) &&
        mem_addr_o == ADDR_W'($past(mem_addr_o, 2) + ADDR_W'(1)))));

  p_bad_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && bad_cnt && !uncor_i) |=> (done_o && !mem_en_o));

  p_uncor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && uncor_i) |=> (done_o && err_o && !mem_en_o));

  p_err_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !uncor_i) |=> !err_o);

  p_err_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_o) |-> $past(accept));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> busy_q);

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_q);
endmodule

bind rs_err_apply rs_err_apply_chk #(.BYTES(BYTES), .MAX_CORR(MAX_CORR)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .uncor_i(uncor_i), .cnt_i(cnt_i),
  .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/test_rs_err_apply.sv
`timescale 1ns/1ps
module test_rs_err_apply;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        uncor = 1'b0;
  logic [2:0]  cnt = '0;
  logic [35:0] idx_l = '0, mask_l = '0;
  logic        mem_en, mem_we, done, err;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0] ram [512];
  logic [7:0] exp_mem [512];

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  typedef struct { string req; int lat; bit err; int st; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  rs_err_apply i_rs_err_apply (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .uncor_i(uncor), .cnt_i(cnt),
    .idx_list_i(idx_l), .mask_list_i(mask_l),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done), .err_o(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else mem_rdata <= ram[mem_addr];
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) check("R7", "unexpected done", 1, 0);
      else begin
        item_t it;
        int bad, first;
        it = q.pop_front();
        check(it.req, "latency", cyc - it.st, it.lat);
        check(it.req, "err_o", int'(err), int'(it.err));
        bad = 0; first = -1;
        for (int a = 0; a < 512; a++)
          if (ram[a] !== exp_mem[a]) begin
            bad++;
            if (first < 0) first = a;
          end
        checks++;
        if (bad != 0) begin
          errors++;
          $display("FAIL %s ram byte %0d: actual=%0d expected=%0d", it.req, first,
                   ram[first], exp_mem[first]);
        end
      end
    end
  end

  // R1 model: symbol s covers bits 9(s-1)..9(s-1)+8, bit n = byte n/8 bit n%8
  function automatic bit apply_exp(input int s, input int m);
    if (s < 1 || 9 * (s - 1) >= 4096) return 0;
    for (int t = 0; t < 9; t++) begin
      int a;
      a = 9 * (s - 1) + t;
      if (a < 4096 && m[t]) exp_mem[a / 8][a % 8] = ~exp_mem[a / 8][a % 8];
    end
    return 1;
  endfunction

  task automatic run_job(input string req, input int c, input bit u,
                         input logic [35:0] il, input logic [35:0] ml, input bit poke);
    item_t it;
    int v = 0, s = 0;
    if (!u && c >= 1 && c <= 4)
      for (int k = 0; k < c; k++)
        if (apply_exp(int'(il[k*9 +: 9]), int'(ml[k*9 +: 9]))) v++; else s++;
    @(negedge clk);
    cnt = 3'(c); uncor = u; idx_l = il; mask_l = ml; start = 1'b1;
    it.req = req; it.lat = 4 * v + s + 1; it.err = u; it.st = cyc;
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      cnt = 3'd2; idx_l = {9'd0, 9'd0, 9'd31, 9'd30}; mask_l = '1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  function automatic logic [35:0] pk(input int a, input int b, input int c, input int d);
    return {9'(d), 9'(c), 9'(b), 9'(a)};
  endfunction

  initial begin
    for (int a = 0; a < 512; a++) begin
      ram[a] = 8'(a * 37 + 5);
      exp_mem[a] = ram[a];
    end
    repeat (3) @(negedge clk);
    check("R7", "reset done_o", int'(done), 0);
    check("R6", "reset err_o", int'(err), 0);
    check("R7", "reset mem_en_o", int'(mem_en), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_job("R1", 1, 0, pk(10, 0, 0, 0), pk(9'h1FF, 0, 0, 0), 0);
    run_job("R1", 1, 0, pk(8, 0, 0, 0), pk(9'h155, 0, 0, 0), 0);
    run_job("R2", 2, 0, pk(100, 101, 0, 0), pk(9'h0F3, 9'h1A5, 0, 0), 0);
    run_job("R9", 4, 0, pk(3, 4, 5, 3), pk(9'h1C1, 9'h0FF, 9'h101, 9'h0C3), 0);
    run_job("R9", 2, 0, pk(40, 40, 0, 0), pk(9'h17E, 9'h17E, 0, 0), 0);
    run_job("R3", 1, 0, pk(456, 0, 0, 0), pk(9'h1FF, 0, 0, 0), 0);
    run_job("R3", 1, 0, pk(455, 0, 0, 0), pk(9'h1FF, 0, 0, 0), 0);
    run_job("R4", 3, 0, pk(0, 457, 511, 0), pk(9'h1FF, 9'h1FF, 9'h1FF, 0), 0);
    run_job("R4", 3, 0, pk(1, 500, 2, 0), pk(9'h101, 9'h1FF, 9'h0AA, 0), 0);
    run_job("R5", 0, 0, pk(12, 13, 0, 0), pk(9'h1FF, 9'h1FF, 0, 0), 0);
    run_job("R5", 5, 0, pk(12, 13, 14, 15), pk(9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF), 0);
    run_job("R5", 7, 0, pk(12, 13, 14, 15), pk(9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF), 0);
    run_job("R6", 2, 1, pk(60, 61, 0, 0), pk(9'h1FF, 9'h1FF, 0, 0), 0);
    repeat (3) @(negedge clk);
    check("R6", "err_o held", int'(err), 1);
    run_job("R6", 1, 0, pk(62, 0, 0, 0), pk(9'h011, 0, 0, 0), 0);
    run_job("R8", 1, 0, pk(20, 0, 0, 0), pk(9'h0F0, 0, 0, 0), 1);
    run_job("R7", 4, 0, pk(200, 300, 400, 456), pk(9'h001, 9'h100, 9'h081, 9'h003), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule